// File: doc/BRIEF.md
# Per-Slave Interrupt Status Collector

This block gathers interrupt events from up to sixteen slave devices on a serial management bus and keeps them in a bank of sticky status bits. Every slave owns one 8-bit status byte. The bytes are packed four to a 32-bit word, so the default build has four status words. An incoming event pulse on any bit of a slave's byte sets that bit. The bit then stays set until software clears it by writing a one to it.

A 16-bit enable mask selects which slaves may drive the single level-sensitive interrupt line to the processor. The line is registered. It is high while at least one enabled slave has a nonzero status byte, and it drops once every enabled byte has been cleared or masked. Software reaches the status words and the mask through a simple register port. That port has a write strobe, a read strobe, a byte address and read data that is returned one cycle after the read strobe.

Top module: `slv_irq_collect`

## Requirements
- R1: Slave n (0..15) maps to the status word at address 0x20 + 4*(n/4), in bits [8*(n mod 4)+7 : 8*(n mod 4)]. Input `evt_set` bit 8*n+b sets status bit b of slave n at the next clock edge.
- R2: A status bit that has been set stays set when no clear for it is written, regardless of later event activity.
- R3: A write to a status word address clears exactly the bits where `reg_wdata` is 1 and leaves the other bits unchanged. A write of 0xFFFFFFFF clears the whole word.
- R4: When an event and a clear reach the same status bit in the same cycle, the event wins and the bit ends up set.
- R5: The enable mask is a read/write register at address 0x30. Bit n enables slave n. Writes take `reg_wdata[15:0]`, and bits [31:16] read as zero.
- R6: `irq_o` goes high on the clock edge after any enabled slave has a nonzero status byte. A slave whose enable bit is 0 never raises `irq_o`.
- R7: `irq_o` goes low on the clock edge after the last enabled nonzero byte is cleared or its enable bit is removed.
- R8: After a synchronous reset, all status bits are zero, the enable mask is zero, and `irq_o` and `reg_rdata` are zero.
- R9: A write to an address that is neither an aligned status word nor 0x30 changes nothing, and a read of such an address returns zero.
- R10: `reg_rdata` is loaded only on a clock edge where `reg_rd_en` is high. It shows the addressed register as it was before that edge, and it holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 128 | Per-slave event pulses, 8 bits per slave, slave n at bits [8n+7:8n] |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data (status: ones to clear; mask: new value) |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered level interrupt summary |

## Verification
A status bit lost or set in the wrong place appears at the next read of its word, and `irq_o` shows the same fault one cycle after the bad state. A mask bit that is wrong only shows at `irq_o`, so each mask case is checked with a slave pending on both sides of the mask. Every latency check samples `irq_o` both before and after the edge on which it should change. This catches a missing or extra summary register. Clears that collide with events, and writes to addresses that are misaligned or unmapped, are each followed by a read-back of the word they could have disturbed.

// File: rtl/slv_irq_pkg.sv
package slv_irq_pkg;
  typedef enum logic [1:0] {
    HIT_NONE   = 2'd0,
    HIT_STATUS = 2'd1,
    HIT_ENABLE = 2'd2
  } reg_hit_e;
endpackage

// File: rtl/slv_irq_status_word.sv
module slv_irq_status_word #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q
);
  // set has priority over clear on the same bit
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_i) | set_i;
  end

  // R4: an event always leaves its bit set
  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> ((q & $past(set_i)) == $past(set_i)));

  // R2: bits without a clear never fall
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (($past(q) & ~$past(clr_i) & ~q) == '0));

  // R3: cleared bits without a colliding event are zero
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> ((q & $past(clr_i) & ~$past(set_i)) == '0));
endmodule

// File: rtl/slv_irq_regif.sv
module slv_irq_regif
  import slv_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_WORDS   = 4,
  parameter int unsigned NUM_SLV     = 16,
  parameter int unsigned STATUS_BASE = 'h20,
  parameter int unsigned ENABLE_ADDR = 'h30
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_WORDS*DATA_W-1:0]   status_words,
  output logic [NUM_WORDS*DATA_W-1:0]   clr_words,
  output logic [NUM_SLV-1:0]            enable_q,
  output logic [DATA_W-1:0]             rdata
);
  localparam int unsigned WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int unsigned SPAN_B   = NUM_WORDS * (DATA_W / 8);

  reg_hit_e              hit;
  logic [ADDR_W-1:0]     off;
  logic [WIDX_W-1:0]     word_idx;

  always_comb begin
    hit      = HIT_NONE;
    off      = addr - ADDR_W'(STATUS_BASE);
    word_idx = off[WIDX_W+1:2];
    if (addr == ADDR_W'(ENABLE_ADDR)) begin
      hit = HIT_ENABLE;
    end else if ((addr >= ADDR_W'(STATUS_BASE)) && (off < ADDR_W'(SPAN_B)) &&
                 (addr[1:0] == 2'b00)) begin
      hit = HIT_STATUS;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr
    assign clr_words[w*DATA_W +: DATA_W] =
      (wr_en && (hit == HIT_STATUS) && (word_idx == WIDX_W'(w))) ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
    end else if (wr_en && (hit == HIT_ENABLE)) begin
      enable_q <= wdata[NUM_SLV-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (hit)
        HIT_STATUS: rdata <= status_words[int'(word_idx)*DATA_W +: DATA_W];
        HIT_ENABLE: rdata <= DATA_W'(enable_q);
        default:    rdata <= '0;
      endcase
    end
  end

  // R10: read data holds without a read strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !rd_en) |=> $stable(rdata));

  // R5: mask bits above the slave count read back as zero
  a_r5_mask_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (!rst && rd_en && (hit == HIT_ENABLE)) |=> (rdata[DATA_W-1:NUM_SLV] == '0));
endmodule

// File: rtl/slv_irq_summary.sv
module slv_irq_summary #(
  parameter int unsigned NUM_SLV = 16,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SLV*BYTE_W-1:0] status,
  input  logic [NUM_SLV-1:0]        enable,
  output logic                      irq
);
  logic [NUM_SLV-1:0] pend;

  for (genvar s = 0; s < NUM_SLV; s++) begin : g_pend
    assign pend[s] = (|status[s*BYTE_W +: BYTE_W]) & enable[s];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend;
  end

  // R6: an enabled pending slave raises the line one edge later
  a_r6_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (!rst && (|pend)) |=> irq);

  // R7: no enabled pending slave drops the line one edge later
  a_r7_irq_fall: assert property (@(posedge clk) disable iff (rst)
    (!rst && !(|pend)) |=> !irq);
endmodule

// File: rtl/slv_irq_collect.sv
module slv_irq_collect #(
  parameter int unsigned NUM_SLV     = 16,
  parameter int unsigned SLV_BYTE_W  = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned STATUS_BASE = 'h20,
  parameter int unsigned ENABLE_ADDR = 'h30
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SLV*SLV_BYTE_W-1:0] evt_set,
  input  logic                          reg_wr_en,
  input  logic                          reg_rd_en,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic                          irq_o
);
  localparam int unsigned SLV_PER_WORD = DATA_W / SLV_BYTE_W;
  localparam int unsigned NUM_WORDS    = (NUM_SLV + SLV_PER_WORD - 1) / SLV_PER_WORD;
  localparam int unsigned STATUS_W     = NUM_WORDS * DATA_W;
  localparam int unsigned EVT_W        = NUM_SLV * SLV_BYTE_W;

  logic [STATUS_W-1:0] set_words;
  logic [STATUS_W-1:0] clr_words;
  logic [STATUS_W-1:0] status_words;
  logic [NUM_SLV-1:0]  enable_q;

  assign set_words = STATUS_W'(evt_set);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    slv_irq_status_word #(.DATA_W(DATA_W)) word_i (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_words[w*DATA_W +: DATA_W]),
      .clr_i (clr_words[w*DATA_W +: DATA_W]),
      .q     (status_words[w*DATA_W +: DATA_W])
    );
  end

  slv_irq_regif #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_WORDS   (NUM_WORDS),
    .NUM_SLV     (NUM_SLV),
    .STATUS_BASE (STATUS_BASE),
    .ENABLE_ADDR (ENABLE_ADDR)
  ) regif_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (reg_wr_en),
    .rd_en        (reg_rd_en),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .status_words (status_words),
    .clr_words    (clr_words),
    .enable_q     (enable_q),
    .rdata        (reg_rdata)
  );

  slv_irq_summary #(
    .NUM_SLV (NUM_SLV),
    .BYTE_W  (SLV_BYTE_W)
  ) summary_i (
    .clk    (clk),
    .rst    (rst),
    .status (status_words[EVT_W-1:0]),
    .enable (enable_q),
    .irq    (irq_o)
  );
endmodule

// File: tb/slv_irq_collect_tb.sv
`timescale 1ns/1ps
module slv_irq_collect_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] evt_set = '0;
  logic         reg_wr_en = 1'b0;
  logic         reg_rd_en = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         irq_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slv_irq_collect dut_i (
    .clk(clk), .rst(rst), .evt_set(evt_set),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input int slv, input logic [7:0] b);
    evt_set[slv*8 +: 8] = b;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R8 rdata after reset", reg_rdata, 32'h0);
    check("R8 irq after reset", {31'b0, irq_o}, 32'h0);
    for (int w = 0; w < 4; w++) begin
      rd(8'h20 + 8'(4*w), d);
      check("R8 status word zero", d, 32'h0);
    end
    rd(8'h30, d);
    check("R8 mask zero", d, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    pulse(5, 8'hA5);
    pulse(15, 8'h81);
    pulse(10, 8'h3C);
    rd(8'h24, d); check("R1 slave5 byte1 of word 0x24", d, 32'h0000A500);
    rd(8'h2C, d); check("R1 slave15 byte3 of word 0x2C", d, 32'h81000000);
    rd(8'h28, d); check("R1 slave10 byte2 of word 0x28", d, 32'h003C0000);
    rd(8'h20, d); check("R1 word 0x20 untouched", d, 32'h0);
    repeat (3) tick();
    rd(8'h24, d); check("R2 sticky after idle", d, 32'h0000A500);
    check("R6 masked slaves keep irq low", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(8'h24, 32'h00002100);
    rd(8'h24, d); check("R3 partial clear", d, 32'h00008400);
    wr(8'h2C, 32'hFFFFFFFF);
    rd(8'h2C, d); check("R3 full word clear", d, 32'h0);
    wr(8'h28, 32'hFFFFFFFF);
    rd(8'h28, d); check("R3 full word clear 0x28", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(8'h30, 32'hFFFFAAAA);
    check("R6 irq not before summary edge", {31'b0, irq_o}, 32'h0);
    tick();
    check("R6 irq after enable of pending slave5", {31'b0, irq_o}, 32'h1);
    rd(8'h30, d); check("R5 mask readback", d, 32'h0000AAAA);
    pulse(4, 8'h10);
    wr(8'h24, 32'h0000FF00);
    check("R7 irq still high on clearing edge", {31'b0, irq_o}, 32'h1);
    tick();
    check("R7 irq low after clear, R6 slave4 masked", {31'b0, irq_o}, 32'h0);
    rd(8'h24, d); check("R3 slave4 kept while slave5 cleared", d, 32'h00000010);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    evt_set[4*8 +: 8] = 8'h10;
    reg_wr_en = 1'b1; reg_addr = 8'h24; reg_wdata = 32'h00000010;
    @(negedge clk);
    evt_set = '0; reg_wr_en = 1'b0;
    rd(8'h24, d); check("R4 event beats clear same bit", d, 32'h00000010);
    evt_set[4*8 +: 8] = 8'h02;
    reg_wr_en = 1'b1; reg_addr = 8'h24; reg_wdata = 32'h000000FF;
    @(negedge clk);
    evt_set = '0; reg_wr_en = 1'b0;
    rd(8'h24, d); check("R4 event kept, other bit cleared", d, 32'h00000002);
    wr(8'h24, 32'hFFFFFFFF);
  endtask

  task automatic t_mask_drop();
    logic [31:0] d;
    pulse(7, 8'h01);
    tick();
    check("R6 enabled slave7 raises irq", {31'b0, irq_o}, 32'h1);
    wr(8'h30, 32'h0);
    check("R7 irq high on mask edge", {31'b0, irq_o}, 32'h1);
    tick();
    check("R7 irq low after mask removed", {31'b0, irq_o}, 32'h0);
    rd(8'h24, d); check("R2 status kept after unmask", d, 32'h01000000);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h34, 32'hFFFFFFFF);
    wr(8'h1C, 32'hFFFFFFFF);
    wr(8'h26, 32'hFFFFFFFF);
    rd(8'h24, d); check("R9 stray writes leave status", d, 32'h01000000);
    rd(8'h30, d); check("R9 stray writes leave mask", d, 32'h0);
    rd(8'h34, d); check("R9 unmapped read zero", d, 32'h0);
    tick();
    check("R9 irq unchanged", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_rdata();
    logic [31:0] d;
    rd(8'h24, d); check("R10 read value", d, 32'h01000000);
    wr(8'h24, 32'hFFFFFFFF);
    pulse(0, 8'hFF);
    check("R10 rdata held without read", reg_rdata, 32'h01000000);
    rd(8'h24, d); check("R10 fresh read after clear", d, 32'h0);
    rd(8'h20, d); check("R1 slave0 byte0 of word 0x20", d, 32'h000000FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_clear();
    t_enable();
    t_collision();
    t_mask_drop();
    t_unmapped();
    t_rdata();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R1 got=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule